// File: doc/BRIEF.md
# Hex Frequency Command Parser

This block reads a stream of received bytes, for example from a UART receiver, and interprets short ASCII commands that control a programmable frequency source. It holds a 64-bit tuning word. Its upper 32 bits drive the synthesizer as the active tuning word. A one-cycle strobe tells the synthesizer when that active value has changed.

There are two commands. A status query is the single letter S. It makes the block send a text reply on a byte-wide valid/ready transmit port. The reply holds a fixed reference-frequency string, which is supplied on an input, followed by the full tuning word as 16 hex digits. A set command is `F=` followed by hex digits and ended by CR or LF. It rewrites the tuning word one nibble at a time, starting from the most significant digit. Nibbles that are not sent keep their old values. Any malformed set command is dropped without touching the word.

Top module: `freq_cmd_parser`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tx_valid` and `tuning_update` are low. After reset, `tuning_word` equals bits 63:32 of the parameter `RESET_WORD`.
- R2: A byte `S` (0x53) or `s` (0x73) received at the start of a line starts a reply. The reply is `R=`, then the REF_LEN bytes of `ref_text` with the most significant byte first, then CR LF, then `F=`, then the 16 nibbles of the stored word as upper-case hex with the most significant nibble first, then CR LF. Each byte is transferred when `tx_valid` and `tx_ready` are both high. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R3: A line `F=` followed by N hex digits (1 ≤ N ≤ 16) and then CR (0x0D) or LF (0x0A) writes digit k (k = 0 first) into word bits [63-4k : 60-4k]. All other nibbles keep their previous values.
- R4: The hex digits `0`-`9`, `A`-`F` and `a`-`f` are all accepted. The command letters are accepted in either case (`F` or `f`, `S` or `s`).
- R5: The stored word does not change, and the rest of the line up to CR or LF is discarded, in any of these cases: a non-hex byte among the digits, a 17th digit, a byte other than `=` after `F`, or a line that starts with any other byte.
- R6: `tuning_word` always equals bits 63:32 of the stored word.
- R7: `tuning_update` is high for exactly one cycle: the first cycle in which `tuning_word` shows a new value. It stays low when a command leaves bits 63:32 unchanged, including a command that changes only the lower 32 bits.
- R8: Bytes that arrive while a reply is in progress are dropped. They have no effect on the stored word.
- R9: The word is written only when the terminator arrives. Before the terminator, `tuning_word` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| ref_text | input | 8*REF_LEN | Fixed reference-frequency text, first character in the top byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Downstream accepts the reply byte |
| tuning_word | output | ACT_W | Upper ACT_W bits of the stored word |
| tuning_update | output | 1 | One-cycle pulse when `tuning_word` changes |

## Verification
The assertions check four things on every cycle. Every reply starts with `R`. A stalled reply byte holds still. `tuning_word` moves only in a cycle where `tuning_update` is high, and every pulse marks a real, single-cycle change. Reset leaves the outputs quiet. The contents of a command cannot be seen in any one cycle, so only the bench's scenarios can show them. These are: which nibble each digit lands in, that unsent nibbles are kept, the full text of the reply, that aborted lines are discarded, and that bytes arriving during a reply are dropped. The bench sweeps every accepted hex character and every digit count from 1 to 16, and checks the stored word through the status reply.

// File: rtl/freq_cmd_pkg.sv
package freq_cmd_pkg;

    localparam logic [7:0] CH_CR  = 8'h0D;
    localparam logic [7:0] CH_LF  = 8'h0A;
    localparam logic [7:0] CH_EQ  = 8'h3D;
    localparam logic [7:0] CH_R   = 8'h52;
    localparam logic [7:0] CH_F_U = 8'h46;
    localparam logic [7:0] CH_F_L = 8'h66;
    localparam logic [7:0] CH_S_U = 8'h53;
    localparam logic [7:0] CH_S_L = 8'h73;

    typedef enum logic [1:0] {
        PS_LINE_START,
        PS_WANT_EQ,
        PS_DIGITS,
        PS_SKIP_LINE
    } parse_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    function automatic logic is_term(input logic [7:0] c);
        return (c == CH_CR) || (c == CH_LF);
    endfunction

    function automatic logic is_hex(input logic [7:0] c);
        return (c >= 8'h30 && c <= 8'h39) ||
               (c >= 8'h41 && c <= 8'h46) ||
               (c >= 8'h61 && c <= 8'h66);
    endfunction

    function automatic logic [3:0] hex_value(input logic [7:0] c);
        logic [7:0] t;
        if (c <= 8'h39)      t = c - 8'h30;
        else if (c <= 8'h46) t = c - 8'h37;
        else                 t = c - 8'h57;
        return t[3:0];
    endfunction

    function automatic logic [7:0] nibble_char(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/freq_cmd_rx.sv
module freq_cmd_rx
    import freq_cmd_pkg::*;
#(
    parameter int DIGITS = 16,
    parameter int ACT_W  = 32,
    parameter logic [4*DIGITS-1:0] RESET_WORD = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  byte_beat_t            beat,
    input  logic                  reply_busy,
    output logic                  status_req,
    output logic [4*DIGITS-1:0]   word,
    output logic                  word_update
);
    localparam int W  = 4 * DIGITS;
    localparam int CW = $clog2(DIGITS + 1);

    parse_state_t    state, state_n;
    logic [CW-1:0]   cnt, cnt_n;
    logic [W-1:0]    stage, stage_n;
    logic            take, commit;

    assign take = beat.valid && !reply_busy;

    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        stage_n    = stage;
        commit     = 1'b0;
        status_req = 1'b0;
        if (take) begin
            unique case (state)
                PS_LINE_START: begin
                    if (beat.data == CH_S_U || beat.data == CH_S_L)
                        status_req = 1'b1;
                    else if (beat.data == CH_F_U || beat.data == CH_F_L)
                        state_n = PS_WANT_EQ;
                    else if (!is_term(beat.data))
                        state_n = PS_SKIP_LINE;
                end
                PS_WANT_EQ: begin
                    if (beat.data == CH_EQ) begin
                        state_n = PS_DIGITS;
                        cnt_n   = '0;
                        stage_n = word;
                    end else if (is_term(beat.data)) begin
                        state_n = PS_LINE_START;
                    end else begin
                        state_n = PS_SKIP_LINE;
                    end
                end
                PS_DIGITS: begin
                    if (is_term(beat.data)) begin
                        commit  = 1'b1;
                        state_n = PS_LINE_START;
                    end else if (is_hex(beat.data) && cnt < CW'(DIGITS)) begin
                        for (int k = 0; k < DIGITS; k++) begin
                            if (cnt == CW'(k))
                                stage_n[(DIGITS-1-k)*4 +: 4] = hex_value(beat.data);
                        end
                        cnt_n = cnt + CW'(1);
                    end else begin
                        state_n = PS_SKIP_LINE;
                    end
                end
                PS_SKIP_LINE: begin
                    if (is_term(beat.data))
                        state_n = PS_LINE_START;
                end
                default: state_n = PS_LINE_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PS_LINE_START;
            cnt         <= '0;
            stage       <= '0;
            word        <= RESET_WORD;
            word_update <= 1'b0;
        end else begin
            state       <= state_n;
            cnt         <= cnt_n;
            stage       <= stage_n;
            word_update <= commit && (stage[W-1 -: ACT_W] != word[W-1 -: ACT_W]);
            if (commit)
                word <= stage;
        end
    end

endmodule

// File: rtl/freq_cmd_tx.sv
module freq_cmd_tx
    import freq_cmd_pkg::*;
#(
    parameter int DIGITS  = 16,
    parameter int REF_LEN = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [4*DIGITS-1:0]   word,
    input  logic [8*REF_LEN-1:0]  ref_text,
    output logic                  busy,
    output logic                  tx_valid,
    output logic [7:0]            tx_data,
    input  logic                  tx_ready
);
    localparam int W        = 4 * DIGITS;
    localparam int RSP_LEN  = REF_LEN + DIGITS + 8;
    localparam int IW       = $clog2(RSP_LEN);
    localparam int REF_BASE = 2;
    localparam int SEP_BASE = REF_BASE + REF_LEN;
    localparam int DIG_BASE = SEP_BASE + 4;

    logic          active;
    logic [IW-1:0] idx;
    logic [W-1:0]  snap;
    logic [7:0]    ch;

    always_comb begin
        ch = 8'h00;
        if (idx == IW'(0)) ch = CH_R;
        if (idx == IW'(1)) ch = CH_EQ;
        for (int k = 0; k < REF_LEN; k++) begin
            if (idx == IW'(REF_BASE + k))
                ch = ref_text[(REF_LEN-1-k)*8 +: 8];
        end
        if (idx == IW'(SEP_BASE))     ch = CH_CR;
        if (idx == IW'(SEP_BASE + 1)) ch = CH_LF;
        if (idx == IW'(SEP_BASE + 2)) ch = CH_F_U;
        if (idx == IW'(SEP_BASE + 3)) ch = CH_EQ;
        for (int k = 0; k < DIGITS; k++) begin
            if (idx == IW'(DIG_BASE + k))
                ch = nibble_char(snap[(DIGITS-1-k)*4 +: 4]);
        end
        if (idx == IW'(RSP_LEN - 2)) ch = CH_CR;
        if (idx == IW'(RSP_LEN - 1)) ch = CH_LF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            snap   <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
                snap   <= word;
            end
        end else if (tx_ready) begin
            if (idx == IW'(RSP_LEN - 1)) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + IW'(1);
            end
        end
    end

    assign busy     = active;
    assign tx_valid = active;
    assign tx_data  = ch;

endmodule

// File: rtl/freq_cmd_parser.sv
module freq_cmd_parser
    import freq_cmd_pkg::*;
#(
    parameter int DIGITS  = 16,
    parameter int ACT_W   = 32,
    parameter int REF_LEN = 16,
    parameter logic [4*DIGITS-1:0] RESET_WORD = 64'h1999_9999_9999_9900
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic [8*REF_LEN-1:0]  ref_text,
    output logic                  tx_valid,
    output logic [7:0]            tx_data,
    input  logic                  tx_ready,
    output logic [ACT_W-1:0]      tuning_word,
    output logic                  tuning_update
);
    localparam int W = 4 * DIGITS;

    byte_beat_t   rx_beat;
    logic         busy;
    logic         status_req;
    logic [W-1:0] word;

    assign rx_beat = '{valid: rx_valid, data: rx_data};

    freq_cmd_rx #(
        .DIGITS     (DIGITS),
        .ACT_W      (ACT_W),
        .RESET_WORD (RESET_WORD)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .beat        (rx_beat),
        .reply_busy  (busy),
        .status_req  (status_req),
        .word        (word),
        .word_update (tuning_update)
    );

    freq_cmd_tx #(
        .DIGITS  (DIGITS),
        .REF_LEN (REF_LEN)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (status_req),
        .word     (word),
        .ref_text (ref_text),
        .busy     (busy),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready)
    );

    assign tuning_word = word[W-1 -: ACT_W];

endmodule

// File: rtl/freq_cmd_checker.sv
module freq_cmd_checker #(
    parameter int ACT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic [ACT_W-1:0] tuning_word,
    input logic             tuning_update
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !tuning_update));

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_reply_lead_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data == 8'h52));

    assert_word_moves_on_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        !tuning_update |-> $stable(tuning_word));

    assert_pulse_real_change_R7: assert property (@(posedge clk) disable iff (rst)
        tuning_update |-> (tuning_word != $past(tuning_word)));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        tuning_update |=> !tuning_update);

endmodule

bind freq_cmd_parser freq_cmd_checker #(.ACT_W(ACT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .tuning_word   (tuning_word),
    .tuning_update (tuning_update)
);

// File: tb/freq_cmd_parser_test.sv
module freq_cmd_parser_test;
    localparam int DIGITS  = 16;
    localparam int ACT_W   = 32;
    localparam int REF_LEN = 16;
    localparam int RSP     = REF_LEN + DIGITS + 8;
    localparam logic [63:0] RST_WORD = 64'h1999_9999_9999_9900;
    localparam logic [8*REF_LEN-1:0] REF = "50000123.4567890";
    localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_data = 8'h00;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_ready = 1'b0;
    logic [ACT_W-1:0] tuning_word;
    logic             tuning_update;

    int          checks = 0;
    int          fails = 0;
    int          pulses = 0;
    logic [63:0] model = RST_WORD;
    logic [7:0]  rsp_buf [RSP];
    int          rsp_got;

    always #5 clk = ~clk;

    freq_cmd_parser #(
        .DIGITS(DIGITS), .ACT_W(ACT_W), .REF_LEN(REF_LEN), .RESET_WORD(RST_WORD)
    ) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .ref_text(REF), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tuning_word(tuning_word),
        .tuning_update(tuning_update)
    );

    always @(negedge clk) if (!rst && tuning_update) pulses++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] v, input bit lower);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        return (lower ? 8'h57 : 8'h37) + {4'h0, v};
    endfunction

    function automatic logic [7:0] exp_rsp(input int i);
        if (i == 0) return 8'h52;
        if (i == 1) return 8'h3D;
        if (i < 2 + REF_LEN) return REF[(REF_LEN-1-(i-2))*8 +: 8];
        if (i == REF_LEN + 2) return 8'h0D;
        if (i == REF_LEN + 3) return 8'h0A;
        if (i == REF_LEN + 4) return 8'h46;
        if (i == REF_LEN + 5) return 8'h3D;
        if (i < RSP - 2) return hexc(model[(DIGITS-1-(i-REF_LEN-6))*4 +: 4], 1'b0);
        if (i == RSP - 2) return 8'h0D;
        return 8'h0A;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic collect_rsp(input bit stall, input string req);
        int cyc = 0;
        rsp_got = 0;
        while (rsp_got < RSP && cyc < 4 * RSP + 20) begin
            tx_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (tx_valid && tx_ready) begin
                rsp_buf[rsp_got] = tx_data;
                rsp_got++;
            end
            @(negedge clk);
            cyc++;
        end
        tx_ready = 1'b0;
        chk({req, " reply length"}, 64'(rsp_got), 64'(RSP));
        for (int i = 0; i < RSP; i++)
            chk({req, " reply byte"}, (i < rsp_got) ? 64'(rsp_buf[i]) : 64'hX, 64'(exp_rsp(i)));
        chk({req, " tx idle after reply"}, 64'(tx_valid), 64'd0);
    endtask

    task automatic status(input bit lower, input bit stall);
        send_byte(lower ? 8'h73 : 8'h53);
        collect_rsp(stall, "R2 R3");
    endtask

    task automatic do_set(input int n, input logic [63:0] val, input bit lower,
                          input bit use_lf, input string req);
        logic [31:0] up0 = model[63:32];
        int          p0  = pulses;
        logic [63:0] nm  = model;
        send_byte(lower ? 8'h66 : 8'h46);
        send_byte(8'h3D);
        for (int k = 0; k < n; k++) begin
            nm[(15-k)*4 +: 4] = val[(15-k)*4 +: 4];
            send_byte(hexc(val[(15-k)*4 +: 4], lower));
        end
        send_byte(use_lf ? 8'h0A : 8'h0D);
        @(negedge clk);
        model = nm;
        chk({req, " R6 tuning_word"}, 64'(tuning_word), 64'(model[63:32]));
        chk("R7 update pulse count", 64'(pulses - p0), (model[63:32] != up0) ? 64'd1 : 64'd0);
    endtask

    task automatic expect_unchanged(input string req, input int p0);
        @(negedge clk);
        chk({req, " word unchanged"}, 64'(tuning_word), 64'(model[63:32]));
        chk({req, " no pulse"}, 64'(pulses - p0), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        logic [63:0] v;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 tx_valid in reset", 64'(tx_valid), 64'd0);
        chk("R1 tuning_update in reset", 64'(tuning_update), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", 64'(tuning_word), 64'(RST_WORD[63:32]));
        chk("R1 tx idle", 64'(tx_valid), 64'd0);
        status(1'b0, 1'b0);

        // R4: every accepted hex character as a one-digit set command
        for (int d = 0; d < 16; d++) begin
            for (int lc = 0; lc < 2; lc++) begin
                if (d < 10 && lc == 1) continue;
                do_set(1, {4'(d), 60'h0}, lc[0], d[0], "R4 R3");
            end
        end
        status(1'b1, 1'b1);

        // R3: every digit count, with a rotated pattern
        for (int n = 1; n <= 16; n++) begin
            v = (PAT << (4 * n)) | (PAT >> (64 - 4 * n));
            do_set(n, v, n[1], n[0], "R3");
            status(n[2], n[0]);
        end

        // R7: change in the lower half only, then rewrite the same upper half
        v = {model[63:32], 32'h0BAD_F000};
        do_set(16, v, 1'b0, 1'b0, "R7 lower-only");
        status(1'b0, 1'b0);
        do_set(8, model, 1'b1, 1'b1, "R7 same upper");

        // R5: aborted commands leave the word untouched
        p0 = pulses;
        send_str("F=12G4"); send_byte(8'h0D);
        expect_unchanged("R5 bad digit", p0);
        p0 = pulses;
        send_str("F=ABCDEF0123456789A"); send_byte(8'h0D);
        expect_unchanged("R5 seventeen digits", p0);
        p0 = pulses;
        send_str("FX12"); send_byte(8'h0A);
        expect_unchanged("R5 missing equals", p0);
        p0 = pulses;
        send_str("QF=7777"); send_byte(8'h0D);
        expect_unchanged("R5 junk line", p0);
        status(1'b0, 1'b1);
        do_set(4, 64'h7E57_0000_0000_0000, 1'b0, 1'b0, "R5 recovery");

        // R9: no effect before the terminator
        p0 = pulses;
        send_str("F=ABCD1234");
        @(negedge clk);
        chk("R9 before terminator", 64'(tuning_word), 64'(model[63:32]));
        chk("R9 no early pulse", 64'(pulses - p0), 64'd0);
        send_byte(8'h0A);
        @(negedge clk);
        model[63:32] = 32'hABCD_1234;
        chk("R9 after terminator", 64'(tuning_word), 64'(model[63:32]));
        chk("R9 R7 pulse", 64'(pulses - p0), 64'd1);

        // R8: bytes during a reply are dropped
        p0 = pulses;
        send_byte(8'h53);
        tx_ready = 1'b0;
        send_str("F=0000"); send_byte(8'h0D);
        collect_rsp(1'b0, "R8");
        expect_unchanged("R8 dropped", p0);
        status(1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule